// File: doc/BRIEF.md
# USB Device Interrupt Status Controller

This block gathers the interrupt sources of a small USB device controller into one 32-bit pending register. The sources are the ten endpoint directions (OUT and IN for endpoints 0 to 4), a one-millisecond frame tick and a device-state-change summary. Software reads the pending bits and acknowledges each one by writing a one to it. A matching enable register masks each source, and a routing register sends each enabled, pending bit to one of two level-sensitive interrupt lines.

Endpoint bits are set when the transfer engine reports that an endpoint finished. This happens when its byte count has run out or software asked for the endpoint to be skipped. Under a separate enable for each direction, an endpoint bit is also set when a NAK handshake goes out on that endpoint. The frame bit only counts ticks while the bus supply is present and the device is attached. The device bit follows a separate change vector, and it is set again in every cycle in which any bit of that vector is still high.

The block sits behind a plain register port with single-cycle writes and a combinational read mux. There are three words: pending at offset 0x20, enable at 0x24 and routing at 0x28.

Top module: `usb_irq_ctrl`

## Requirements
- R1: A pulse on `ep_done_i[k]` sets pending bit k. Bit 2n is endpoint n OUT and bit 2n+1 is endpoint n IN, for n = 0 to 4.
- R2: A pulse on an odd (IN) bit of `nak_i` sets the matching pending bit only while `nak_in_en_i` is 1.
- R3: A pulse on an even (OUT) bit of `nak_i` sets the matching pending bit only while `nak_out_en_i` is 1.
- R4: A write to offset 0x20 clears every pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R5: If a set event and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up 1.
- R6: A pulse on `ms_tick_i` sets pending bit 30 only while both `vbus_ok_i` and `dev_conn_i` are 1.
- R7: Pending bit 31 is set in every cycle in which any bit of `dev_chg_i` is 1.
- R8: After reset, the pending, enable and routing registers read zero. Bits 29:10 of all three read zero at all times. Enable (0x24) and routing (0x28) store bits 9:0, 30 and 31 as written.
- R9: An interrupt line is asserted only by a bit that is both pending and enabled. With the enable register at zero, both lines stay low.
- R10: An enabled pending bit with routing bit 0 drives `irq_o[0]`, and one with routing bit 1 drives `irq_o[1]`. Each line is the OR of all sources routed to it and stays high as long as such a source stays pending.
- R11: An event present before a clock edge shows in the read data and on the interrupt lines right after that edge, and not before it. With no event and no clear, the pending register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ep_done_i | input | 10 | Endpoint-finished strobes, bit 2n OUT and 2n+1 IN |
| nak_i | input | 10 | NAK-sent strobes, same bit order |
| nak_in_en_i | input | 1 | Lets IN NAK strobes set pending bits |
| nak_out_en_i | input | 1 | Lets OUT NAK strobes set pending bits |
| ms_tick_i | input | 1 | One-cycle millisecond pulse |
| vbus_ok_i | input | 1 | Debounced bus-supply present |
| dev_conn_i | input | 1 | Device attached to the bus |
| dev_chg_i | input | 8 | Device-state-change vector |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 2 | Level interrupt lines 0 and 1 |

## Verification
The bench builds the block with five endpoints and an eight-bit change vector. With these defaults, all ten endpoint bits and the fixed positions 30 and 31 exist, so the full reserved gap 29:10 can be checked for read-as-zero. The table drives each source alone and in mixes: NAKs with each direction gate on and off, and ticks with every qualifier combination. Directed tests then cover the partial write-one-to-clear, the collision of set and clear, the one-edge latency, and the routing of two sources onto separate lines and onto the same line.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned FRAME_BIT = 30;
  localparam int unsigned DEV_BIT   = 31;
  localparam int unsigned NUM_LINES = 2;

  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_EN    = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_ROUTE = 8'h28;

  // implemented bits: endpoint field plus frame and device bits
  function automatic logic [REG_W-1:0] impl_mask(input int unsigned ep_bits);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < ep_bits; i++) m[i] = 1'b1;
    m[FRAME_BIT] = 1'b1;
    m[DEV_BIT]   = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/usb_irq_evt_map.sv
module usb_irq_evt_map
  import usb_irq_pkg::*;
#(
  parameter int unsigned EP_BITS = 10,
  parameter int unsigned CHG_W   = 8
) (
  input  logic [EP_BITS-1:0] ep_done_i,
  input  logic [EP_BITS-1:0] nak_i,
  input  logic               nak_in_en_i,
  input  logic               nak_out_en_i,
  input  logic               ms_tick_i,
  input  logic               vbus_ok_i,
  input  logic               dev_conn_i,
  input  logic [CHG_W-1:0]   dev_chg_i,
  output logic [REG_W-1:0]   set_o
);
  logic [EP_BITS-1:0] ep_set;

  for (genvar i = 0; i < EP_BITS; i++) begin : g_ep
    if (i % 2 == 1) begin : g_in
      assign ep_set[i] = ep_done_i[i] | (nak_i[i] & nak_in_en_i);
    end else begin : g_out
      assign ep_set[i] = ep_done_i[i] | (nak_i[i] & nak_out_en_i);
    end
  end

  always_comb begin
    set_o                  = '0;
    set_o[EP_BITS-1:0]     = ep_set;
    set_o[FRAME_BIT]       = ms_tick_i & vbus_ok_i & dev_conn_i;
    set_o[DEV_BIT]         = |dev_chg_i;
  end
endmodule

// File: rtl/usb_irq_pend_reg.sv
module usb_irq_pend_reg
  import usb_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] pend_o
);
  logic [REG_W-1:0] pend_q;
  logic [REG_W-1:0] set_m, clr_m;

  assign set_m = set_i & MASK;
  assign clr_m = clr_i & MASK;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_m) | set_m;
  end

  assign pend_o = pend_q;

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_m != '0) |=> ((pend_q & $past(set_m)) == $past(set_m)));

  assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_m & ~set_m) != '0) |=> ((pend_q & $past(clr_m & ~set_m)) == '0));

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_m == '0) && (clr_m == '0)) |=> $stable(pend_q));
endmodule

// File: rtl/usb_irq_router.sv
module usb_irq_router
  import usb_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [REG_W-1:0]     pend_i,
  input  logic [REG_W-1:0]     en_i,
  input  logic [REG_W-1:0]     route_i,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [REG_W-1:0] live;
  assign live = pend_i & en_i;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    if (l == 0) begin : g_l0
      assign irq_o[l] = |(live & ~route_i);
    end else begin : g_l1
      assign irq_o[l] = |(live & route_i);
    end
  end

  assert_no_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> (irq_o == '0));

  assert_route0_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_i == '0) |-> !irq_o[1]);
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int unsigned NUM_EP = 5,
  parameter int unsigned CHG_W  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2*NUM_EP-1:0]  ep_done_i,
  input  logic [2*NUM_EP-1:0]  nak_i,
  input  logic                 nak_in_en_i,
  input  logic                 nak_out_en_i,
  input  logic                 ms_tick_i,
  input  logic                 vbus_ok_i,
  input  logic                 dev_conn_i,
  input  logic [CHG_W-1:0]     dev_chg_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam int unsigned      EP_BITS = 2 * NUM_EP;
  localparam logic [REG_W-1:0] IMPL    = impl_mask(EP_BITS);

  logic [REG_W-1:0] set_vec, clr_vec, pend, en_q, route_q;
  logic             wr_pend, wr_en, wr_route;

  assign wr_pend  = reg_we_i && (reg_addr_i == OFS_PEND);
  assign wr_en    = reg_we_i && (reg_addr_i == OFS_EN);
  assign wr_route = reg_we_i && (reg_addr_i == OFS_ROUTE);
  assign clr_vec  = wr_pend ? reg_wdata_i : '0;

  usb_irq_evt_map #(.EP_BITS(EP_BITS), .CHG_W(CHG_W)) u_evt (
    .ep_done_i   (ep_done_i),
    .nak_i       (nak_i),
    .nak_in_en_i (nak_in_en_i),
    .nak_out_en_i(nak_out_en_i),
    .ms_tick_i   (ms_tick_i),
    .vbus_ok_i   (vbus_ok_i),
    .dev_conn_i  (dev_conn_i),
    .dev_chg_i   (dev_chg_i),
    .set_o       (set_vec)
  );

  usb_irq_pend_reg #(.MASK(IMPL)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .pend_o(pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      route_q <= '0;
    end else begin
      if (wr_en)    en_q    <= reg_wdata_i & IMPL;
      if (wr_route) route_q <= reg_wdata_i & IMPL;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      OFS_PEND:  reg_rdata_o = pend;
      OFS_EN:    reg_rdata_o = en_q;
      OFS_ROUTE: reg_rdata_o = route_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  usb_irq_router u_route (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .en_i   (en_q),
    .route_i(route_q),
    .irq_o  (irq_o)
  );

  assert_rsvd_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~IMPL) == '0);

  assert_en_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (en_q == $past(reg_wdata_i & IMPL)));
endmodule

// File: tb/usb_irq_ctrl_tb.sv
module usb_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  ep_done = '0, nak = '0;
  logic        nak_in_en = 1'b0, nak_out_en = 1'b0;
  logic        ms_tick = 1'b0, vbus_ok = 1'b0, dev_conn = 1'b0;
  logic [7:0]  dev_chg = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h20;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usb_irq_ctrl #(.NUM_EP(5), .CHG_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ep_done_i(ep_done), .nak_i(nak),
    .nak_in_en_i(nak_in_en), .nak_out_en_i(nak_out_en), .ms_tick_i(ms_tick),
    .vbus_ok_i(vbus_ok), .dev_conn_i(dev_conn), .dev_chg_i(dev_chg),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [9:0]  ep;
    logic [9:0]  nak;
    logic        nin, nout, tick, vbus, conn;
    logic [7:0]  chg;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{10'h001, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0000_0001}, // R1
    '{10'h200, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0000_0200}, // R1
    '{10'h000, 10'h3FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0000_02AA}, // R2
    '{10'h000, 10'h3FF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0000_0155}, // R3
    '{10'h000, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0000_0000}, // R2 R3
    '{10'h000, 10'h000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 32'h4000_0000}, // R6
    '{10'h000, 10'h000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 32'h0000_0000}, // R6
    '{10'h000, 10'h000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 32'h0000_0000}, // R6
    '{10'h000, 10'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 32'h0000_0000}, // R6
    '{10'h000, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10, 32'h8000_0000}, // R7
    '{10'h0F0, 10'h003, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0000_00F2}  // R1 R2 R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ep_done = '0; nak = '0; nak_in_en = 1'b0; nak_out_en = 1'b0;
    ms_tick = 1'b0; vbus_ok = 1'b0; dev_conn = 1'b0; dev_chg = '0;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse_ep(input logic [9:0] v);
    @(negedge clk);
    ep_done = v;
    @(posedge clk);
    @(negedge clk);
    ep_done = '0;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R8 reset state
    reg_rd(8'h20, rd); check("R8 pend reset", rd, 32'h0);
    reg_rd(8'h24, rd); check("R8 en reset", rd, 32'h0);
    reg_rd(8'h28, rd); check("R8 route reset", rd, 32'h0);
    check("R9 irq reset", {30'h0, irq}, 32'h0);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R6 R7
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      ep_done = VECS[k].ep; nak = VECS[k].nak;
      nak_in_en = VECS[k].nin; nak_out_en = VECS[k].nout;
      ms_tick = VECS[k].tick; vbus_ok = VECS[k].vbus; dev_conn = VECS[k].conn;
      dev_chg = VECS[k].chg;
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
      reg_rd(8'h20, rd);
      check($sformatf("vector %0d", k), rd, VECS[k].exp);
      reg_wr(8'h20, 32'hFFFF_FFFF);
      reg_rd(8'h20, rd);
      check($sformatf("R4 clear after vector %0d", k), rd, 32'h0);
    end

    // R8 reserved bits and storage
    reg_wr(8'h24, 32'hFFFF_FFFF);
    reg_rd(8'h24, rd); check("R8 en mask", rd, 32'hC000_03FF);
    reg_wr(8'h28, 32'hFFFF_FFFF);
    reg_rd(8'h28, rd); check("R8 route mask", rd, 32'hC000_03FF);
    reg_wr(8'h24, 32'h0); reg_wr(8'h28, 32'h0);

    // R4 partial clear, zero write
    pulse_ep(10'h3FF);
    reg_wr(8'h20, 32'h0000_000F);
    reg_rd(8'h20, rd); check("R4 partial clear", rd, 32'h0000_03F0);
    reg_wr(8'h20, 32'h0);
    reg_rd(8'h20, rd); check("R4 zero write", rd, 32'h0000_03F0);
    reg_wr(8'h20, 32'hFFFF_FFFF);

    // R5 set beats clear
    pulse_ep(10'h001);
    @(negedge clk);
    ep_done = 10'h001; we = 1'b1; addr = 8'h20; wdata = 32'h0000_0003;
    @(posedge clk);
    @(negedge clk);
    ep_done = '0; we = 1'b0; wdata = '0;
    reg_rd(8'h20, rd); check("R5 set wins", rd, 32'h0000_0001);
    reg_wr(8'h20, 32'hFFFF_FFFF);

    // R11 latency
    @(negedge clk);
    ep_done = 10'h008;
    reg_rd(8'h20, rd); check("R11 before edge", rd, 32'h0);
    @(posedge clk);
    @(negedge clk);
    ep_done = '0;
    reg_rd(8'h20, rd); check("R11 after edge", rd, 32'h0000_0008);
    repeat (3) @(negedge clk);
    reg_rd(8'h20, rd); check("R11 hold", rd, 32'h0000_0008);
    reg_wr(8'h20, 32'hFFFF_FFFF);

    // R9 R10 routing
    pulse_ep(10'h020);
    #1 check("R9 no enable", {30'h0, irq}, 32'h0);
    reg_wr(8'h24, 32'h0000_0020);
    #1 check("R10 line0", {30'h0, irq}, 32'h1);
    reg_wr(8'h28, 32'h0000_0020);
    #1 check("R10 line1", {30'h0, irq}, 32'h2);
    @(negedge clk);
    ms_tick = 1'b1; vbus_ok = 1'b1; dev_conn = 1'b1;
    #1 check("R11 irq before edge", {30'h0, irq}, 32'h2);
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    #1 check("R9 frame not enabled", {30'h0, irq}, 32'h2);
    reg_wr(8'h24, 32'h4000_0020);
    #1 check("R10 both lines", {30'h0, irq}, 32'h3);
    reg_wr(8'h28, 32'h4000_0020);
    #1 check("R10 shared line1", {30'h0, irq}, 32'h2);
    reg_wr(8'h20, 32'h0000_0020);
    #1 check("R10 remaining source", {30'h0, irq}, 32'h2);
    reg_wr(8'h20, 32'h4000_0000);
    #1 check("R10 all cleared", {30'h0, irq}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule